// File: doc/BRIEF.md
# Compare-Capture General Purpose Timer

The block is a 16-bit up-counter with a compare register, a capture register, a programmable prescaler and two event flags. Software programs it over a simple register bus that has a 3-bit address, a write strobe and a 16-bit write word. The bus reads back through a combinational data port. A control word picks the count source, what happens after a compare match, how the compare output pin reacts, which capture-pin edges latch the count, and whether a compare match raises the interrupt line.

The count advances only on a "tick". Depending on the source select, a tick is every system clock, one in every (divider+1) system clocks, or every clock on which an external enable input is high after synchronisation. When the count equals the compare value on a tick, the compare flag is set. The counter then either clears to zero (restart) or carries on upward and wraps at 0xFFFF (free-running). The capture input passes through a two-flop synchroniser and then an edge detector. On a selected edge, the present count is copied to the capture register and the capture flag is set.

Register map (address: content): 0 control, 1 compare value (reset 0xFFFF), 2 capture value (read only), 3 counter (read only), 4 prescaler divider in bits [7:0], 5 status (bit 0 compare flag, bit 1 capture flag, write 1 to clear).

Top module: `gp_cmp_timer`

## Requirements
- R1: The control register resets to 0x0000. Its bits 15..9 always read zero and ignore writes. Bits 8..0 read back as written.
- R2: With control bit 8 = 0 (restart), a tick on which the count equals the compare value loads 0x0000, so the count repeats 0,1,..,C.
- R3: With control bit 8 = 1 (free-running), the count keeps incrementing through the compare value and wraps from 0xFFFF to 0x0000.
- R4: Control bits [3:1] pick the tick source: 000 and codes 100..111 stop the counter, which holds its value.
- R5: Source code 010 gives one tick every (D+1) system clocks, where D is the 8-bit divider at address 4.
- R6: Source code 011 ticks on each clock on which the external enable input, passed through two flops, is high. When that input is low, the count holds.
- R7: Control bit 0 = 0 holds the counter and the prescaler at zero.
- R8: Control bits [7:6] select the capture edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge of the synchronised capture pin copies the count into the capture register.
- R9: A compare match sets status bit 0 and a capture event sets status bit 1. Writing 1 to a status bit clears it, and a new event in the same cycle wins over the clear.
- R10: The interrupt output is high exactly while status bit 0 is set and control bit 4 is 1.
- R11: With control bit 5 = 0, the compare output (idle high) goes low on a match tick and returns high on the next tick.
- R12: With control bit 5 = 1, the compare output inverts on every match tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe, one register write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| ext_en | input | 1 | Asynchronous external count enable |
| cmp_pin | output | 1 | Compare output pin |
| irq | output | 1 | Compare interrupt request |

## Verification
A corrupt count is visible within one read at address 3 and, in restart mode, as a compare period other than C+1 ticks on the compare pin. A prescaler state that is off by one changes the spacing between count steps immediately, so measuring that spacing shows it within a few divider periods. A wrong edge detector or synchroniser shows up three clocks after a pin transition, as a capture value or capture flag that differs from the value read from the frozen counter. Wrong flag handling shows on the interrupt line in the cycle after the status write.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int ADDR_W = 3;
    localparam int SYNC_N = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

    // tick source codes
    localparam logic [2:0] SRC_OFF = 3'b000;
    localparam logic [2:0] SRC_SYS = 3'b001;
    localparam logic [2:0] SRC_DIV = 3'b010;
    localparam logic [2:0] SRC_EXT = 3'b011;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic [6:0] rsvd;
        logic       free_run;
        edge_sel_e  edge_sel;
        logic       om_toggle;
        logic       irq_en;
        logic [2:0] src;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen
    import gpt_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [2:0]    src,
    input  logic [PW-1:0] div,
    input  logic          ext_en_s,
    output logic          tick
);
    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = '0;
        tick  = 1'b0;
        if (run) begin
            unique case (src)
                SRC_SYS: tick = 1'b1;
                SRC_DIV: begin
                    if (pre_q >= div) begin
                        tick  = 1'b1;
                        pre_d = '0;
                    end else begin
                        pre_d = pre_q + PW'(1);
                    end
                end
                SRC_EXT: tick = ext_en_s;
                default: tick = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // prescaler restarts after every divided tick
    assert_prescale_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src == SRC_DIV && tick) |=> pre_q == '0);

    // disabled timer keeps the prescaler at zero
    assert_prescale_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pre_q == '0);
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         free_run,
    input  logic         om_toggle,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic         match_evt,
    output logic         cmp_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         out;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        match_evt = run && tick && (st_q.cnt == cmp_val);
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (match_evt && !free_run) st_d.cnt = '0;
            else                        st_d.cnt = st_q.cnt + W'(1);
        end
        if (run && tick) begin
            if (match_evt)       st_d.out = om_toggle ? ~st_q.out : 1'b0;
            else if (!om_toggle) st_d.out = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, out: 1'b1};
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign cmp_out = st_q.out;

    assert_restart_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !free_run) |=> cnt == '0);

    assert_free_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && free_run) |=> cnt == $past(cnt) + W'(1));

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

    assert_zero_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

    assert_toggle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && om_toggle) |=> cmp_out != $past(cmp_out));
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture
    import gpt_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int STAGES = SYNC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_pin,
    input  edge_sel_e    edge_sel,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_val,
    output logic         cap_evt
);
    typedef struct packed {
        logic         prev;
        logic [W-1:0] val;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    pin_s;
    logic    rise, fall;

    gpt_sync #(.W(1), .STAGES(STAGES)) u_cap_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (cap_pin),
        .q    (pin_s)
    );

    always_comb begin
        st_d      = st_q;
        rise      = pin_s && !st_q.prev;
        fall      = !pin_s && st_q.prev;
        st_d.prev = pin_s;
        unique case (edge_sel)
            EDGE_RISE: cap_evt = rise;
            EDGE_FALL: cap_evt = fall;
            EDGE_BOTH: cap_evt = rise || fall;
            default:   cap_evt = 1'b0;
        endcase
        if (cap_evt) st_d.val = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val = st_q.val;

    assert_capture_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_val == $past(cnt));

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_val));
endmodule

// File: rtl/gp_cmp_timer.sv
module gp_cmp_timer
    import gpt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PRE_W,
    parameter int AW = ADDR_W,
    parameter int SN = SYNC_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic          cap_pin,
    input  logic          ext_en,
    output logic          cmp_pin,
    output logic          irq
);
    localparam logic [15:0] CTRL_MASK = 16'h01FF;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [CW-1:0] cmp;
        logic [PW-1:0] div;
        logic          cmp_flag;
        logic          cap_flag;
    } reg_st_t;

    reg_st_t       rg_d, rg_q;
    logic          ext_s;
    logic          tick;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cap_val;
    logic          match_evt;
    logic          cap_evt;

    gpt_sync #(.W(1), .STAGES(SN)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ext_en),
        .q    (ext_s)
    );

    gpt_tick_gen #(.PW(PW)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (rg_q.ctrl.run),
        .src     (rg_q.ctrl.src),
        .div     (rg_q.div),
        .ext_en_s(ext_s),
        .tick    (tick)
    );

    gpt_counter #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (rg_q.ctrl.run),
        .tick     (tick),
        .free_run (rg_q.ctrl.free_run),
        .om_toggle(rg_q.ctrl.om_toggle),
        .cmp_val  (rg_q.cmp),
        .cnt      (cnt),
        .match_evt(match_evt),
        .cmp_out  (cmp_pin)
    );

    gpt_capture #(.W(CW), .STAGES(SN)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_pin (cap_pin),
        .edge_sel(rg_q.ctrl.edge_sel),
        .cnt     (cnt),
        .cap_val (cap_val),
        .cap_evt (cap_evt)
    );

    always_comb begin
        rg_d = rg_q;
        if (bus_we) begin
            unique case (bus_addr)
                A_CTRL: rg_d.ctrl = ctrl_t'(bus_wdata & CTRL_MASK);
                A_CMP:  rg_d.cmp  = bus_wdata[CW-1:0];
                A_DIV:  rg_d.div  = bus_wdata[PW-1:0];
                A_STAT: begin
                    if (bus_wdata[0]) rg_d.cmp_flag = 1'b0;
                    if (bus_wdata[1]) rg_d.cap_flag = 1'b0;
                end
                default: ;
            endcase
        end
        if (match_evt) rg_d.cmp_flag = 1'b1;
        if (cap_evt)   rg_d.cap_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.cmp  <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = rg_q.ctrl;
            A_CMP:   bus_rdata = 16'(rg_q.cmp);
            A_CAP:   bus_rdata = 16'(cap_val);
            A_CNT:   bus_rdata = 16'(cnt);
            A_DIV:   bus_rdata = 16'(rg_q.div);
            A_STAT:  bus_rdata = {14'b0, rg_q.cap_flag, rg_q.cmp_flag};
            default: bus_rdata = '0;
        endcase
    end

    assign irq = rg_q.cmp_flag && rg_q.ctrl.irq_en;

    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL) |=>
            (rg_q.ctrl[8:0] == $past(bus_wdata[8:0]) && rg_q.ctrl[15:9] == '0));

    assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rg_q.cmp_flag) |-> $past(match_evt));

    assert_flag_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> rg_q.cmp_flag);

    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && rg_q.ctrl.irq_en && !bus_we) |=> irq);
endmodule

// File: tb/gp_cmp_timer_tb.sv
`timescale 1ns/1ps
module gp_cmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cap_pin = 1'b0;
    logic        ext_en = 1'b0;
    logic        cmp_pin;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gp_cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
        .ext_en(ext_en), .cmp_pin(cmp_pin), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #0.5 v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cycles between two successive changes of the counter
    task automatic count_period(output int n);
        logic [15:0] a, b;
        int guard;
        rd(3'd3, a); b = a; guard = 0;
        while (b == a && guard < 200) begin rd(3'd3, b); guard++; end
        a = b; n = 0;
        while (b == a && n < 200) begin rd(3'd3, b); n++; end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd0, v); chk("R1 ctrl reset", v, 16'h0000);
        rd(3'd3, v); chk("R7 count reset", v, 16'h0000);
        chk("R11 pin idle", {15'b0, cmp_pin}, 16'h1);
        chk("R10 irq reset", {15'b0, irq}, 16'h0);
        wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R1 reserved bits", v, 16'h01FF);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_restart;
        logic [15:0] v, prev;
        int bad = 0;
        wr(3'd1, 16'd5);
        wr(3'd0, 16'h0003);
        rd(3'd3, prev);
        for (int i = 0; i < 30; i++) begin
            rd(3'd3, v);
            if (v != ((prev == 16'd5) ? 16'd0 : prev + 16'd1)) bad++;
            if (v > 16'd5) bad++;
            prev = v;
        end
        chk("R2 restart sequence", 16'(bad), 16'd0);
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'h0003);
    endtask

    task automatic t_free;
        logic [15:0] v, prev;
        int bad = 0, wraps = 0, past = 0;
        wr(3'd1, 16'd5);
        wr(3'd0, 16'h0103);
        rd(3'd3, prev);
        for (int i = 0; i < 65600; i++) begin
            rd(3'd3, v);
            if (v != prev + 16'd1) bad++;
            if (prev == 16'hFFFF && v == 16'h0000) wraps++;
            if (prev == 16'd5 && v == 16'd6) past++;
            prev = v;
        end
        chk("R3 free-run step", 16'(bad), 16'd0);
        chk("R3 wrap seen", 16'(wraps), 16'd1);
        chk("R3 passes compare", 16'(past != 0), 16'd1);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_stop_src;
        logic [15:0] a, b;
        wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h0003); idle(10);
        wr(3'd0, 16'h000F); idle(2);
        rd(3'd3, a); idle(10); rd(3'd3, b);
        chk("R4 code 111 holds", b, a);
        chk("R4 value kept", 16'(a != 0), 16'd1);
        wr(3'd0, 16'h0001); idle(2);
        rd(3'd3, b); chk("R4 code 000 holds", b, a);
        wr(3'd0, 16'h0000); rd(3'd3, b);
        chk("R7 disable zeroes", b, 16'h0000);
    endtask

    task automatic t_prescale;
        int n;
        wr(3'd1, 16'hFFFF);
        wr(3'd4, 16'd3);
        wr(3'd0, 16'h0005);
        count_period(n); chk("R5 divider 3", 16'(n), 16'd4);
        wr(3'd4, 16'd0);
        count_period(n); chk("R5 divider 0", 16'(n), 16'd1);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_ext;
        logic [15:0] a, b;
        ext_en = 1'b0;
        wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h0007); idle(5);
        rd(3'd3, a); chk("R6 low holds", a, 16'h0000);
        ext_en = 1'b1; idle(12);
        rd(3'd3, b); chk("R6 high counts", 16'(b >= 16'd8), 16'd1);
        ext_en = 1'b0; idle(4);
        rd(3'd3, a); idle(6); rd(3'd3, b);
        chk("R6 holds again", b, a);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_capture;
        logic [15:0] x, v;
        wr(3'd5, 16'h0003);
        wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h0143); idle(20);
        wr(3'd0, 16'h0141); rd(3'd3, x);
        cap_pin = 1'b1; idle(5);
        rd(3'd2, v); chk("R8 rising captures", v, x);
        rd(3'd5, v); chk("R9 capture flag", v & 16'h2, 16'h2);
        wr(3'd5, 16'h0002);
        rd(3'd5, v); chk("R9 capture flag clear", v & 16'h2, 16'h0);
        wr(3'd0, 16'h0143); idle(7);
        wr(3'd0, 16'h0141); rd(3'd3, v);
        cap_pin = 1'b0; idle(5);
        rd(3'd5, v); chk("R8 falling ignored", v & 16'h2, 16'h0);
        rd(3'd2, v); chk("R8 value kept", v, x);
        wr(3'd0, 16'h01C3); idle(9);
        wr(3'd0, 16'h01C1); rd(3'd3, x);
        cap_pin = 1'b1; idle(5);
        rd(3'd2, v); chk("R8 both rising", v, x);
        wr(3'd0, 16'h01C3); idle(4);
        wr(3'd0, 16'h01C1); rd(3'd3, x);
        cap_pin = 1'b0; idle(5);
        rd(3'd2, v); chk("R8 both falling", v, x);
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'h0003);
    endtask

    task automatic t_irq;
        logic [15:0] v;
        wr(3'd1, 16'd3);
        wr(3'd0, 16'h0013); idle(8);
        chk("R10 irq on match", {15'b0, irq}, 16'h1);
        rd(3'd5, v); chk("R9 compare flag", v & 16'h1, 16'h1);
        wr(3'd0, 16'h0010);
        chk("R10 irq held", {15'b0, irq}, 16'h1);
        wr(3'd5, 16'h0001);
        chk("R10 irq cleared", {15'b0, irq}, 16'h0);
        wr(3'd0, 16'h0003); idle(8);
        wr(3'd0, 16'h0000);
        rd(3'd5, v); chk("R9 flag without enable", v & 16'h1, 16'h1);
        chk("R10 masked", {15'b0, irq}, 16'h0);
        wr(3'd5, 16'h0001);
    endtask

    task automatic t_pulse;
        int n = 0, guard = 0;
        wr(3'd1, 16'd1);
        wr(3'd4, 16'd2);
        wr(3'd0, 16'h0005);
        while (cmp_pin && guard < 100) begin @(negedge clk); guard++; end
        while (!cmp_pin && n < 100) begin @(negedge clk); n++; end
        chk("R11 pulse width", 16'(n), 16'd3);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_toggle;
        logic s;
        int n = 0, guard = 0;
        wr(3'd1, 16'd3);
        wr(3'd0, 16'h0023);
        s = cmp_pin;
        while (cmp_pin == s && guard < 100) begin @(negedge clk); guard++; end
        s = cmp_pin;
        while (cmp_pin == s && n < 100) begin @(negedge clk); n++; end
        chk("R12 toggle period", 16'(n), 16'd4);
        wr(3'd0, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_restart();
        t_free();
        t_stop_src();
        t_prescale();
        t_ext();
        t_capture();
        t_irq();
        t_pulse();
        t_toggle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule